// File: doc/BRIEF.md
# PWM Dual Prescaled Clock Generator

This block turns one master clock into the set of tick enables that a bank of PWM channels counts on. A free-running binary counter yields ticks at the master rate divided by 2, 4, 8 and so on up to 1024. Two independent linear dividers, A and B, each pick one source tick and divide it again by an 8-bit value. The block also drives an undivided tick that is high on every cycle once reset has been released. Every tick output is a single-cycle enable in the master clock domain, never a derived clock.

Software-side configuration arrives through a plain write strobe with a 24-bit data word, written as a whole. A master enable input, driven by the power controller, stops every divided tick when low. The undivided tick keeps running. A divide value of zero keeps that divider silent, so both linear dividers are off after reset until they are programmed.

Top module: `pwm_tick_gen`

## Requirements
- R1: After reset every divide and select field is zero, `tick_a` and `tick_b` never pulse even with `mck_en` high, and `tick_base` is high on every cycle from the second clock edge after `rst_n` rises.
- R2: While `mck_en` is high, `tick_pow[k]` (k = 0..9) is a one-cycle pulse repeating every 2^(k+1) master cycles.
- R3: While `mck_en` is low, `tick_pow`, `tick_a` and `tick_b` stay low and `tick_base` stays high; raising `mck_en` again resumes the divided ticks.
- R4: A select value s picks the source tick: s = 0 is `tick_base`, s = 1..10 is `tick_pow[s-1]` (rate 1/2^s), and s = 11..15 gives no source tick, so that divider never pulses.
- R5: A divide value N > 0 emits one output pulse for every N source ticks, so the output repeats every 2^s * N master cycles.
- R6: A divide value of zero keeps that divider's output permanently low.
- R7: A cycle with `cfg_we` high loads `cfg_wdata` as {div B [23:16], sel B [15:12], div A [11:4], sel A [3:0]}. The new values act from the next cycle, and both dividers restart from a count of zero. With s = 0 and divide value N, the first pulse falls in the Nth cycle after the write edge.
- R8: Dividers A and B run independently: each output rate depends only on its own select and divide fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mck_en | input | 1 | Master enable from the power controller; low stops all divided ticks |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 24 | Configuration word: select and divide fields for A and B |
| tick_base | output | 1 | Undivided tick, high every cycle after reset release |
| tick_pow | output | 10 | Power-of-two ticks; bit k pulses every 2^(k+1) cycles |
| tick_a | output | 1 | Linear divider A output tick |
| tick_b | output | 1 | Linear divider B output tick |

## Verification
The bench measures the gap between consecutive pulses on every power-of-two tick and on both dividers for several select and divide pairs. It includes the extremes of a 1024-cycle source, a divide value of 255, and a divide value of one on the undivided tick. An off-by-one in the counter compare would show up as gaps one source tick long or short. A mixed-up field order would leave one divider running at the other's rate. It drives zero divide values and the out-of-range selects 11 and 15, where a loose decoder would alias onto a real tick. It rewrites a divider mid-count and checks the exact cycle of the first new pulse, which a design that forgot to clear its count would miss. It drops the master enable and checks that only the undivided tick survives.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

  // number of power-of-two stages (divide by 2 .. 2**STAGES)
  localparam int unsigned STAGES = 10;
  // width of a source-select field
  localparam int unsigned SEL_W  = 4;
  // width of a linear divide field
  localparam int unsigned DIV_W  = 8;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [SEL_W-1:0] sel;
  } lin_cfg_t;

  typedef struct packed {
    lin_cfg_t b;
    lin_cfg_t a;
  } mode_cfg_t;

  localparam int unsigned CFG_W = $bits(mode_cfg_t);

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];

  // R1: once released, the synchronised reset stays released until rst_n drops
  a_r1_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n_sync |=> rst_n_sync);

endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output mode_cfg_t        cfg,
  output logic             restart
);

  mode_cfg_t cfg_q;
  mode_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = mode_cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg     = cfg_q;
  assign restart = we;

  // R7: a write lands unchanged in the register on the next cycle
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q == mode_cfg_t'($past(wdata))));

  // R7: without a write the configuration holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q));

endmodule

// File: rtl/pwm_pow2_prescaler.sv
module pwm_pow2_prescaler #(
  parameter int unsigned STAGES = pwm_tick_pkg::STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic [STAGES-1:0] tick_pow
);

  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] cnt_d;

  always_comb begin
    if (en) cnt_d = cnt_q + 1'b1;
    else    cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // stage k fires when the low k+1 counter bits are all ones
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    assign tick_pow[k] = en & (&cnt_q[k:0]);

    // R2: every power-of-two tick lasts a single cycle
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      tick_pow[k] |=> !tick_pow[k]);
  end

  // R2: a slower stage only fires together with every faster stage
  for (genvar k = 1; k < STAGES; k++) begin : g_nest
    a_r2_nested: assert property (@(posedge clk) disable iff (!rst_n)
      tick_pow[k] |-> tick_pow[k-1]);
  end

  // R3: a disabled master clock parks the counter at zero
  a_r3_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_src_sel.sv
module pwm_src_sel #(
  parameter int unsigned STAGES = pwm_tick_pkg::STAGES,
  parameter int unsigned SEL_W  = pwm_tick_pkg::SEL_W
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              tick_base,
  input  logic [STAGES-1:0] tick_pow,
  output logic              src_tick
);

  // codes above STAGES select nothing
  always_comb begin
    src_tick = 1'b0;
    if (sel == '0) src_tick = tick_base;
    for (int k = 0; k < STAGES; k++) begin
      if (sel == SEL_W'(k + 1)) src_tick = tick_pow[k];
    end
  end

endmodule

// File: rtl/pwm_lin_div.sv
module pwm_lin_div #(
  parameter int unsigned DIV_W = pwm_tick_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick_out
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             active;
  logic             wrap;

  always_comb begin
    active   = en && (div_val != '0);
    wrap     = (cnt_q == (div_val - DIV_W'(1)));
    tick_out = active && src_tick && wrap;
    cnt_d    = cnt_q;
    if (restart || !active) begin
      cnt_d = '0;
    end else if (src_tick) begin
      if (wrap) cnt_d = '0;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: an output tick always coincides with a source tick
  a_r5_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> src_tick);

  // R5: the count never reaches the divide value
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val != '0) |-> (cnt_q < div_val));

  // R7: a configuration write restarts the count
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  // R6: a zero divide value keeps the count parked
  a_r6_zero_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mck_en,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              tick_base,
  output logic [STAGES-1:0] tick_pow,
  output logic              tick_a,
  output logic              tick_b
);

  localparam int unsigned NUM_DIV = 2;

  logic      rst_n_sync;
  mode_cfg_t cfg;
  logic      restart;
  lin_cfg_t  lin_cfg [NUM_DIV];
  logic      src_tick [NUM_DIV];
  logic      div_tick [NUM_DIV];

  pwm_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // undivided tick: every cycle once reset is released
  assign tick_base = rst_n_sync;

  pwm_cfg_regs u_cfg_regs (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .cfg     (cfg),
    .restart (restart)
  );

  pwm_pow2_prescaler #(.STAGES(STAGES)) u_prescaler (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .en       (mck_en),
    .tick_pow (tick_pow)
  );

  assign lin_cfg[0] = cfg.a;
  assign lin_cfg[1] = cfg.b;

  for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
    pwm_src_sel #(.STAGES(STAGES), .SEL_W(SEL_W)) u_sel (
      .sel       (lin_cfg[d].sel),
      .tick_base (tick_base),
      .tick_pow  (tick_pow),
      .src_tick  (src_tick[d])
    );

    pwm_lin_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .en       (mck_en),
      .restart  (restart),
      .src_tick (src_tick[d]),
      .div_val  (lin_cfg[d].div),
      .tick_out (div_tick[d])
    );
  end

  assign tick_a = div_tick[0];
  assign tick_b = div_tick[1];

  // R3: with the master clock disabled no divided tick escapes
  a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !mck_en |-> (!tick_a && !tick_b && (tick_pow == '0)));

  // R4: out-of-range selects never produce a divider tick
  a_r4_bad_sel_a: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cfg.a.sel > SEL_W'(STAGES)) |-> !tick_a);
  a_r4_bad_sel_b: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cfg.b.sel > SEL_W'(STAGES)) |-> !tick_b);

  // R6: zero divide value silences the divider
  a_r6_zero_div_a: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cfg.a.div == '0) |-> !tick_a);

endmodule

// File: tb/test_pwm_tick_gen.sv
module test_pwm_tick_gen;

  logic        clk;
  logic        rst_n;
  logic        mck_en;
  logic        cfg_we;
  logic [23:0] cfg_wdata;
  logic        tick_base;
  logic [9:0]  tick_pow;
  logic        tick_a;
  logic        tick_b;

  int checks = 0;
  int errors = 0;

  pwm_tick_gen i_pwm_tick_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .mck_en    (mck_en),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .tick_base (tick_base),
    .tick_pow  (tick_pow),
    .tick_a    (tick_a),
    .tick_b    (tick_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic bit sig(input int id);
    if (id < 10)       return tick_pow[id];
    else if (id == 10) return tick_a;
    else if (id == 11) return tick_b;
    else               return tick_base;
  endfunction

  // counts pulses over a window and the gap between the first two
  task automatic measure(input int id, input int cycles, output int n, output int gap);
    int first = -1;
    int second = -1;
    n = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (sig(id)) begin
        n++;
        if (first < 0)       first = c;
        else if (second < 0) second = c;
      end
    end
    gap = (second >= 0) ? (second - first) : 0;
  endtask

  task automatic write_cfg(input int sel_a, input int div_a, input int sel_b, input int div_b);
    @(negedge clk);
    cfg_wdata = {8'(div_b), 4'(sel_b), 8'(div_a), 4'(sel_a)};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_rate(input int id, input int expect_gap, input string req);
    int n;
    int gap;
    int win = expect_gap * 4 + 4;
    measure(id, win, n, gap);
    check(gap == expect_gap, req, gap, expect_gap);
    check(n >= 3, req, n, 4);
  endtask

  task automatic t_reset();
    int n;
    int gap;
    rst_n = 1'b0; mck_en = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    check(tick_base == 1'b0, "R1 base low in reset", tick_base, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mck_en = 1'b1;
    measure(12, 100, n, gap);
    check(n == 100, "R1 base every cycle", n, 100);
    measure(10, 200, n, gap);
    check(n == 0, "R1 tick_a silent after reset", n, 0);
    measure(11, 200, n, gap);
    check(n == 0, "R1 tick_b silent after reset", n, 0);
  endtask

  task automatic t_pow2();
    for (int k = 0; k < 10; k++) check_rate(k, 1 << (k + 1), "R2 power-of-two rate");
  endtask

  task automatic t_rates();
    write_cfg(3, 5, 2, 3);
    check_rate(10, 40, "R5 A sel3 div5");
    check_rate(11, 12, "R8 B sel2 div3");
    write_cfg(0, 1, 10, 1);
    check_rate(10, 1, "R4 A sel0 div1");
    check_rate(11, 1024, "R4 B sel10 div1");
    write_cfg(1, 255, 5, 2);
    check_rate(10, 510, "R5 A sel1 div255");
    check_rate(11, 64, "R8 B sel5 div2");
  endtask

  task automatic t_zero_div();
    int n;
    int gap;
    write_cfg(0, 0, 1, 0);
    measure(10, 300, n, gap);
    check(n == 0, "R6 A div0 silent", n, 0);
    measure(11, 300, n, gap);
    check(n == 0, "R6 B div0 silent", n, 0);
  endtask

  task automatic t_bad_sel();
    int n;
    int gap;
    write_cfg(11, 1, 15, 1);
    measure(10, 300, n, gap);
    check(n == 0, "R4 sel11 no tick", n, 0);
    measure(11, 300, n, gap);
    check(n == 0, "R4 sel15 no tick", n, 0);
  endtask

  task automatic t_restart();
    write_cfg(0, 6, 0, 3);
    repeat (4) @(negedge clk);
    write_cfg(0, 6, 0, 3);
    // write_cfg returns on the first negedge after the write edge
    for (int i = 1; i <= 6; i++) begin
      if (i > 1) @(negedge clk);
      check(tick_a == (i == 6), "R7 A restart timing", tick_a, (i == 6));
      check(tick_b == (i % 3 == 0), "R7 B restart timing", tick_b, (i % 3 == 0));
    end
  endtask

  task automatic t_disable();
    int bad = 0;
    int n;
    int gap;
    write_cfg(0, 1, 1, 1);
    @(negedge clk);
    mck_en = 1'b0;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (tick_a || tick_b || (tick_pow != '0) || !tick_base) bad++;
    end
    check(bad == 0, "R3 only base while disabled", bad, 0);
    mck_en = 1'b1;
    measure(10, 20, n, gap);
    check(n == 20, "R3 A resumes", n, 20);
    check_rate(0, 2, "R3 tick_pow resumes");
  endtask

  initial begin
    t_reset();
    t_pow2();
    t_rates();
    t_zero_div();
    t_bad_sel();
    t_restart();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule